// File: doc/BRIEF.md
# Packet filter rule engine

This block is a small programmable sequencer that decides, for each received network packet, whether the packet is kept or thrown away. Software first loads a program of up to 64 words into the engine's instruction store through a write port. A start strobe then marks the arrival of a packet, and the engine begins running at address 2. Each word fetches four operands. An operand may be packet bytes read through a byte-addressed buffer port, one of eight scratch registers, or a short immediate. The word applies two arithmetic or compare functions to the operands, then carries out two actions in order. An action may be a no-op, a save into a scratch register, a conditional jump, or a rate-limit step.

A jump to address 0 accepts the packet. A jump to address 1 drops it and raises an event-log strobe. Any other target continues execution at that address. A limit step drops the packet when the selected rate counter has run out, and otherwise counts that counter down by one. Software may preload the four rate counters at any time, and they keep their values from one packet to the next. The scratch registers are cleared at the start of every packet.

Top module: `pkt_rule_engine`

## Requirements
- R1: A write on the instruction port stores the 78-bit word at the 6-bit address. The fields are laid out as follows: operand descriptors 0 to 3 at [77:65], [64:52], [51:39] and [38:26]; function A at [25:22]; function B at [21:18]; first action at [17:9]; second action at [8:0].
- R2: Each 13-bit operand descriptor is split into a source field [12:11], a size field [10:9] and a value field [8:0].
  - Source codes: 00 packet, 01 register, 10 immediate, 11 constant zero.
  - Size codes: 00 is 8 bits, 01 is 16 bits, 10 or 11 is 32 bits.
  - A packet operand reads four bytes, most significant first, starting at the value used as a byte offset. Offsets wrap modulo 512. The operand keeps the leading 1, 2 or 4 bytes.
  - A register operand uses value bits [2:0] as the register index. An immediate is the zero-extended value. Both are then truncated to the size.
  - The buffer address is presented combinationally, and the byte data is returned one clock later.
- R3: Function A combines operands 0 and 1, and function B combines operands 2 and 3. The function codes are:
  - 0: pass the first operand.
  - 1: add. 2: subtract (first minus second). Both are modulo 2^32.
  - 3: AND. 4: OR. 5: XOR.
  - 6: equal. 7: not equal. 8: unsigned less than. 9: unsigned greater than. These four return 1 or 0.
  - Any other code gives 0.
- R4: An action's opcode is in [8:7]: 00 no-op, 01 save, 10 jump, 11 limit. For a jump, bit [6] selects the condition (0: result A non-zero, 1: result B non-zero) and [5:0] gives the target. A jump whose condition is false does nothing.
- R5: A save writes result A (bit [6]=0) or result B (bit [6]=1) into the scratch register indexed by [2:0], with no condition. Later words of the same packet see the new value. All scratch registers read zero at the start of each packet.
- R6: A taken jump to 0 pulses accept for one cycle. A taken jump to 1 pulses drop and log_we together for one cycle. A taken jump to any other target continues at that address. Accept and drop never assert together.
- R7: A limit action uses bit [6] to select its condition, in the same way as a jump, and [1:0] as the rate counter index. When the condition is true and the counter is zero, the packet is dropped without a log strobe. When the condition is true and the counter is non-zero, the counter decrements by one and execution goes on. When the condition is false, the action does nothing.
- R8: The first action executes before the second. A taken jump or a limit drop in the first action cancels the second action. A second limit sees any decrement made by the first.
- R9: A word at address 63 that reaches no decision accepts the packet.
- R10: When pkt_start is sampled at clock edge E, execution begins at address 2. If the n-th executed word decides, accept or drop is high in the cycle after edge E+6n. busy is high from E until that decision, and no decision appears earlier.
- R11: A pkt_start sampled while busy abandons the current packet with no decision output for it, and restarts at address 2 with timing counted from the new strobe.
- R12: A rate counter preload writes the 16-bit value into the selected counter. The value is kept across packets until the next preload or decrement.
- R13: After reset, accept, drop, log_we and busy are low and all rate counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 6 | Instruction store write address |
| imem_wdata | input | 78 | Instruction word to store |
| pkt_start | input | 1 | New packet strobe |
| pkt_raddr | output | 9 | Packet buffer byte offset |
| pkt_rdata | input | 32 | Four packet bytes from the offset, one cycle after the address |
| rate_we | input | 1 | Rate counter preload strobe |
| rate_sel | input | 2 | Rate counter to preload |
| rate_wdata | input | 16 | Preload value |
| accept | output | 1 | Packet accepted pulse |
| drop | output | 1 | Packet dropped pulse |
| log_we | output | 1 | Event log write pulse |
| busy | output | 1 | A packet is being evaluated |

## Verification
The hardest situation to reach is an interaction between both action slots and the persistent rate counters. One example is a second limit that must see the first slot's decrement. Another is a limit cancelled by an earlier taken jump, whose only visible trace is a drop that appears or does not appear several packets later.

Directed programs preload a counter to 1 and arrange the two slots so that a wrong ordering or a missed cancel changes the very next decision. Random forward-jumping programs then run many packets with small preloads, so that counters run out often. A bench model of the instruction set tracks the counters and predicts every decision and its cycle.

// File: rtl/pkt_rule_engine.sv
module pkt_rule_engine #(
  parameter int RATE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        imem_we,
  input  logic [5:0]  imem_waddr,
  input  logic [77:0] imem_wdata,
  input  logic        pkt_start,
  output logic [8:0]  pkt_raddr,
  input  logic [31:0] pkt_rdata,
  input  logic        rate_we,
  input  logic [1:0]  rate_sel,
  input  logic [RATE_W-1:0] rate_wdata,
  output logic        accept,
  output logic        drop,
  output logic        log_we,
  output logic        busy
);
  localparam int DEPTH = 64;
  localparam int NREG = 8;
  localparam int NRATE = 4;
  localparam logic [5:0] FIRST_PC = 6'd2;
  localparam logic [5:0] LAST_PC = 6'd63;
  localparam logic [2:0] EXEC_PH = 3'd5;

  logic [77:0] imem [DEPTH];
  logic [5:0]  pc;
  logic        run;
  logic [2:0]  ph;
  logic [31:0] opnd [4];
  logic [31:0] regs [NREG];
  logic [31:0] regs_n [NREG];
  logic [RATE_W-1:0] rate [NRATE];
  logic [RATE_W-1:0] rate_n [NRATE];
  logic acc_q, drop_q, log_q;

  function automatic logic [12:0] desc(input logic [77:0] i, input int k);
    return i[77-13*k -: 13];
  endfunction

  function automatic logic [8:0] dval(input logic [77:0] i, input int k);
    return i[73-13*k -: 9];
  endfunction

  function automatic logic [31:0] fit(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'd0, v[7:0]};
      2'd1:    return {16'd0, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] alu(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      4'd0: return a;
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      4'd6: return {31'd0, a == b};
      4'd7: return {31'd0, a != b};
      4'd8: return {31'd0, a < b};
      4'd9: return {31'd0, a > b};
      default: return 32'd0;
    endcase
  endfunction

  wire [77:0] ins = imem[pc];
  wire [1:0]  cap_k = ph[1:0] - 2'd1;
  wire [12:0] cap_d = desc(ins, int'(cap_k));
  logic [31:0] cap_val;

  assign pkt_raddr = dval(ins, int'(ph[1:0]));

  always_comb begin
    case (cap_d[12:11])
      2'd0: case (cap_d[10:9])
              2'd0:    cap_val = {24'd0, pkt_rdata[31:24]};
              2'd1:    cap_val = {16'd0, pkt_rdata[31:16]};
              default: cap_val = pkt_rdata;
            endcase
      2'd1:    cap_val = fit(regs[cap_d[2:0]], cap_d[10:9]);
      2'd2:    cap_val = fit({23'd0, cap_d[8:0]}, cap_d[10:9]);
      default: cap_val = 32'd0;
    endcase
  end

  wire [31:0] res_a = alu(ins[25:22], opnd[0], opnd[1]);
  wire [31:0] res_b = alu(ins[21:18], opnd[2], opnd[3]);

  logic [8:0]  act;
  logic [31:0] cv;
  logic fin, jmp, dec_acc, dec_drop, dec_log;
  logic [5:0] tgt;

  always_comb begin
    regs_n = regs;
    rate_n = rate;
    fin = 1'b0; jmp = 1'b0; tgt = pc;
    dec_acc = 1'b0; dec_drop = 1'b0; dec_log = 1'b0;
    for (int a = 0; a < 2; a++) begin
      act = (a == 0) ? ins[17:9] : ins[8:0];
      cv = act[6] ? res_b : res_a;
      if (!fin) begin
        case (act[8:7])
          2'b01: regs_n[act[2:0]] = cv;
          2'b10: if (cv != 32'd0) begin
            fin = 1'b1;
            if (act[5:0] == 6'd0) dec_acc = 1'b1;
            else if (act[5:0] == 6'd1) begin dec_drop = 1'b1; dec_log = 1'b1; end
            else begin jmp = 1'b1; tgt = act[5:0]; end
          end
          2'b11: if (cv != 32'd0) begin
            if (rate_n[act[1:0]] == '0) begin fin = 1'b1; dec_drop = 1'b1; end
            else rate_n[act[1:0]] = rate_n[act[1:0]] - 1'b1;
          end
          default: ;
        endcase
      end
    end
    if (!fin && pc == LAST_PC) dec_acc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
    if (run && !pkt_start && ph != 3'd0 && ph != EXEC_PH) opnd[cap_k] <= cap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; ph <= 3'd0; pc <= FIRST_PC;
      acc_q <= 1'b0; drop_q <= 1'b0; log_q <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= 32'd0;
      for (int i = 0; i < NRATE; i++) rate[i] <= '0;
    end else begin
      acc_q <= 1'b0; drop_q <= 1'b0; log_q <= 1'b0;
      if (pkt_start) begin
        run <= 1'b1; ph <= 3'd0; pc <= FIRST_PC;
        for (int i = 0; i < NREG; i++) regs[i] <= 32'd0;
      end else if (run) begin
        if (ph != EXEC_PH) ph <= ph + 3'd1;
        else begin
          ph <= 3'd0;
          regs <= regs_n;
          rate <= rate_n;
          acc_q <= dec_acc; drop_q <= dec_drop; log_q <= dec_log;
          if (dec_acc || dec_drop) run <= 1'b0;
          else if (jmp) pc <= tgt;
          else pc <= pc + 6'd1;
        end
      end
      if (rate_we) rate[rate_sel] <= rate_wdata;
    end
  end

  assign accept = acc_q;
  assign drop   = drop_q;
  assign log_we = log_q;
  assign busy   = run;
endmodule

// File: rtl/pkt_rule_engine_chk.sv
module pkt_rule_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic pkt_start,
  input logic accept,
  input logic drop,
  input logic log_we,
  input logic busy
);
  logic [2:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= 3'd0;
    else if (pkt_start || slot == 3'd5) slot <= 3'd0;
    else slot <= slot + 3'd1;
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) !(accept && drop));
  assert_log_drop_R6: assert property (@(posedge clk) disable iff (!rst_n) log_we |-> drop);
  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (busy && !accept && !drop));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pkt_start) |=> (!busy && !accept && !drop));
  assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || drop) |-> (!busy && $past(busy)));
  assert_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || drop) |-> (slot == 3'd0));
endmodule

bind pkt_rule_engine pkt_rule_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .accept(accept),
  .drop(drop), .log_we(log_we), .busy(busy)
);

// File: tb/pkt_rule_engine_bench.sv
`timescale 1ns/1ps
module pkt_rule_engine_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, imem_we, pkt_start, rate_we;
  logic [5:0] imem_waddr;
  logic [77:0] imem_wdata;
  logic [8:0] pkt_raddr;
  logic [31:0] pkt_rdata;
  logic [1:0] rate_sel;
  logic [15:0] rate_wdata;
  logic accept, drop, log_we, busy;

  pkt_rule_engine u_pkt_rule_engine (.*);

  logic [7:0]  pkt [512];
  logic [77:0] prog [64];
  logic [31:0] mreg [8];
  logic [15:0] mrate [4];
  int checks = 0, fails = 0;

  always @(posedge clk)
    pkt_rdata <= {pkt[pkt_raddr], pkt[pkt_raddr + 9'd1], pkt[pkt_raddr + 9'd2], pkt[pkt_raddr + 9'd3]};

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #700000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] opd(input int src, input int sz, input int val);
    return {src[1:0], sz[1:0], val[8:0]};
  endfunction
  function automatic logic [8:0] aj(input int c, input int t);  return {2'b10, c[0], t[5:0]}; endfunction
  function automatic logic [8:0] as_(input int f, input int r); return {2'b01, f[0], 3'd0, r[2:0]}; endfunction
  function automatic logic [8:0] al(input int c, input int i);  return {2'b11, c[0], 4'd0, i[1:0]}; endfunction
  function automatic logic [77:0] mk(input logic [12:0] o0, input logic [12:0] o1, input logic [12:0] o2,
                                     input logic [12:0] o3, input int fa, input int fb,
                                     input logic [8:0] a0, input logic [8:0] a1);
    return {o0, o1, o2, o3, fa[3:0], fb[3:0], a0, a1};
  endfunction

  function automatic logic [31:0] m_op(input logic [12:0] d);
    logic [31:0] raw;
    logic [8:0] o;
    o = d[8:0];
    case (d[12:11])
      2'd0: begin
        raw = {pkt[o], pkt[o + 9'd1], pkt[o + 9'd2], pkt[o + 9'd3]};
        if (d[10:9] == 2'd0) return raw >> 24;
        if (d[10:9] == 2'd1) return raw >> 16;
        return raw;
      end
      2'd1: raw = mreg[d[2:0]];
      2'd2: raw = {23'd0, d[8:0]};
      default: return 32'd0;
    endcase
    if (d[10:9] == 2'd0) return raw & 32'hff;
    if (d[10:9] == 2'd1) return raw & 32'hffff;
    return raw;
  endfunction

  function automatic logic [31:0] m_fn(input logic [3:0] f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      0: return x;       1: return x + y;   2: return x - y;
      3: return x & y;   4: return x | y;   5: return x ^ y;
      6: return (x == y) ? 1 : 0;  7: return (x != y) ? 1 : 0;
      8: return (x < y) ? 1 : 0;   9: return (x > y) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model(output logic [2:0] res, output int n);
    logic [5:0] pc;
    logic [77:0] w;
    logic [31:0] o [4];
    logic [31:0] r [2];
    logic [8:0] a;
    logic [31:0] cv;
    bit fin, jmp;
    logic [5:0] tgt;
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    pc = 2; n = 0; res = 3'b000;
    while (n < 2000) begin
      n++;
      w = prog[pc];
      for (int k = 0; k < 4; k++) o[k] = m_op(w[77-13*k -: 13]);
      r[0] = m_fn(w[25:22], o[0], o[1]);
      r[1] = m_fn(w[21:18], o[2], o[3]);
      fin = 0; jmp = 0; tgt = 0;
      for (int s = 0; s < 2; s++) begin
        a = (s == 0) ? w[17:9] : w[8:0];
        cv = r[a[6]];
        if (!fin) begin
          if (a[8:7] == 2'b01) mreg[a[2:0]] = cv;
          else if (a[8:7] == 2'b10 && cv != 0) begin
            fin = 1;
            if (a[5:0] == 0) res = 3'b100;
            else if (a[5:0] == 1) res = 3'b011;
            else begin jmp = 1; tgt = a[5:0]; end
          end else if (a[8:7] == 2'b11 && cv != 0) begin
            if (mrate[a[1:0]] == 0) begin fin = 1; res = 3'b010; end
            else mrate[a[1:0]] = mrate[a[1:0]] - 1;
          end
        end
      end
      if (fin && !jmp) break;
      if (jmp) pc = tgt;
      else if (pc == 63) begin res = 3'b100; break; end
      else pc = pc + 1;
    end
  endtask

  task automatic load(input int a, input logic [77:0] w);
    @(negedge clk);
    imem_we = 1; imem_waddr = a[5:0]; imem_wdata = w;
    @(negedge clk);
    imem_we = 0;
    prog[a] = w;
  endtask

  task automatic preload(input int i, input int v);
    @(negedge clk);
    rate_we = 1; rate_sel = i[1:0]; rate_wdata = v[15:0];
    @(negedge clk);
    rate_we = 0;
    mrate[i] = v[15:0];
  endtask

  task automatic run_pkt(input string tag, input bit restart);
    logic [2:0] exp;
    int n;
    bit early;
    model(exp, n);
    early = 0;
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    if (restart) begin
      repeat (3) begin @(negedge clk); if (accept | drop | log_we) early = 1; end
      pkt_start = 1;
      @(negedge clk); pkt_start = 0;
      if (accept | drop | log_we) early = 1;
    end
    repeat (6*n - 1) begin
      @(negedge clk);
      if (accept | drop | log_we | !busy) early = 1;
    end
    @(negedge clk);
    chk(!early, {tag, " R10 decision before its slot"}, 64'(early), 0);
    chk({accept, drop, log_we} == exp && !busy, {tag, " decision"}, {busy, accept, drop, log_we}, 64'(exp));
    @(negedge clk);
  endtask

  function automatic logic [77:0] rand_ins(input int pc);
    logic [12:0] o [4];
    logic [8:0] a [2];
    int r;
    for (int k = 0; k < 4; k++) o[k] = opd($urandom % 4, $urandom % 4, $urandom % 512);
    for (int s = 0; s < 2; s++) begin
      a[s] = 9'($urandom);
      if (a[s][8:7] == 2'b10) begin
        r = $urandom % 4;
        if (r == 0 || pc == 63) a[s][5:0] = 6'($urandom % 2);
        else if (r == 1) a[s][5:0] = 6'd1;
        else a[s][5:0] = 6'(pc + 1 + $urandom % (63 - pc));
      end
    end
    return mk(o[0], o[1], o[2], o[3], $urandom % 12, $urandom % 12, a[0], a[1]);
  endfunction

  localparam logic [12:0] IMM1 = 13'h1001;
  localparam logic [12:0] Z = 13'h0;
  localparam logic [8:0] NOP = 9'h0;

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 0; imem_we = 0; imem_waddr = 0; imem_wdata = 0;
    pkt_start = 0; rate_we = 0; rate_sel = 0; rate_wdata = 0;
    for (int i = 0; i < 512; i++) pkt[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 4; i++) mrate[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({accept, drop, log_we, busy} == 0, "R13 reset outputs", {accept, drop, log_we, busy}, 0);

    for (int i = 0; i < 64; i++) load(i, 78'd0);
    run_pkt("R9 all no-op program falls off end", 0);

    load(2, mk(IMM1, Z, Z, Z, 0, 0, aj(0, 0), NOP));
    run_pkt("R1 R6 jump to 0 accepts", 0);
    load(2, mk(IMM1, Z, Z, Z, 0, 0, aj(0, 1), NOP));
    run_pkt("R6 jump to 1 drops and logs", 0);

    load(2, mk(opd(2, 0, 0), Z, Z, Z, 0, 0, aj(0, 1), NOP));
    load(3, mk(IMM1, Z, Z, Z, 0, 0, aj(0, 0), NOP));
    run_pkt("R4 false condition not taken", 0);

    load(2, mk(opd(2, 1, 9'h1AB), opd(2, 0, 5), Z, Z, 1, 0, as_(0, 5), NOP));
    load(3, mk(opd(1, 1, 5), opd(2, 1, 9'h1B0), Z, Z, 6, 0, aj(0, 1), NOP));
    run_pkt("R5 saved register read back", 0);

    pkt[100] = 8'h12; pkt[101] = 8'h34; pkt[102] = 8'h56; pkt[103] = 8'h78;
    pkt[200] = 8'h12; pkt[201] = 8'h34;
    pkt[510] = 8'h12; pkt[511] = 8'h34; pkt[0] = 8'h56; pkt[1] = 8'h78;
    load(2, mk(opd(0, 1, 100), opd(0, 1, 200), opd(0, 2, 100), opd(0, 2, 510), 7, 7, aj(0, 1), aj(1, 1)));
    load(3, mk(IMM1, Z, opd(2, 0, 9'h1AB), opd(2, 1, 9'h0AB), 0, 7, aj(1, 1), aj(0, 0)));
    run_pkt("R2 packet sizes wrap and immediate truncation", 0);

    load(2, mk(opd(2, 0, 5), opd(2, 0, 7), opd(2, 0, 7), opd(2, 0, 5), 2, 8, aj(1, 1), aj(0, 0)));
    load(3, 78'd0);
    run_pkt("R3 subtract wrap and less-than", 0);

    preload(2, 2);
    load(2, mk(IMM1, Z, Z, Z, 0, 0, al(0, 2), aj(0, 0)));
    run_pkt("R7 limit decrement 2 to 1", 0);
    run_pkt("R7 limit decrement 1 to 0", 0);
    run_pkt("R7 limit exhausted drops", 0);
    preload(2, 1);
    run_pkt("R12 preload restores counter", 0);

    preload(1, 1);
    load(2, mk(IMM1, Z, Z, Z, 0, 0, aj(0, 0), al(0, 1)));
    run_pkt("R8 taken jump cancels limit", 0);
    load(2, mk(IMM1, Z, Z, Z, 0, 0, al(0, 1), aj(0, 0)));
    run_pkt("R8 counter still 1 after cancel", 0);
    preload(3, 1);
    load(2, mk(IMM1, Z, Z, Z, 0, 0, al(0, 3), al(0, 3)));
    run_pkt("R8 second limit sees first decrement", 0);

    load(2, 78'd0);
    load(3, mk(IMM1, Z, Z, Z, 0, 0, aj(0, 1), NOP));
    run_pkt("R11 restart while busy", 1);

    for (int p = 0; p < 12; p++) begin
      for (int i = 2; i < 64; i++) load(i, rand_ins(i));
      for (int q = 0; q < 12; q++) begin
        for (int b = 0; b < 16; b++) pkt[$urandom % 512] = 8'($urandom);
        if ($urandom % 3 == 0) preload($urandom % 4, $urandom % 4);
        run_pkt("R10 random program", 0);
      end
    end
    summary();
  end
endmodule